// File: doc/BRIEF.md
# Programmable Clock Ratio Controller

This block derives three clock-enable pulse streams (core, bus and peripheral) from a single base clock. A 16-bit control word, written over a one-cycle write strobe and always visible on a read-back port, sets the ratio of each stream. Each stream is produced as a one-base-cycle tick. Other logic in the same base clock domain uses these ticks as count enables, so no real clock is divided or gated.

Each domain has a 3-bit code field that selects its divide ratio from a small table. Undefined codes saturate to a ratio of 8 and raise no error. A multiplier-enable bit sets the rate shared by all three dividers. When the bit is set, every base cycle qualifies. When it is clear, a divide-by-6 prescaler lets only one base cycle in six through. A write resets the prescaler and all three divider counters in the same edge, so the new ratios apply to all domains together from a common phase.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset the control word reads 0x0E0A. The first ticks follow that value: core on every cycle, bus every 2nd cycle, peripheral every 4th cycle.
- R2: A write stores all 16 bits of `wr_data`, and `ctl_q` shows them in the cycle after the write edge. While `wr_en` is low, `ctl_q` holds its value whatever `wr_data` carries.
- R3: The core ratio is selected by bits 8:6. Codes 0,1,2,3,4 give ratios 1,2,3,4,5.
- R4: The bus ratio is selected by bits 5:3, using the same table as the core ratio (codes 0 to 4 give 1 to 5).
- R5: The peripheral ratio is selected by bits 2:0. Codes 0,1,2,3,4 give ratios 2,3,4,6,8.
- R6: When bit 10 is 0, every domain's period is multiplied by 6. When bit 10 is 1, every base cycle counts.
- R7: Counting restarts on the cycle after a write edge, which is index 0. A domain of effective period M ticks first on index M-1 and then every M cycles.
- R8: Each tick lasts exactly one base cycle. The peripheral tick is never high on two consecutive cycles.
- R9: Core and bus codes 5, 6 and 7, and peripheral codes 5, 6 and 7, all give a ratio of 8 and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Value written to the control word |
| ctl_q | output | 16 | Read-back of the control word |
| core_tick | output | 1 | Core domain enable pulse |
| bus_tick | output | 1 | Bus domain enable pulse |
| per_tick | output | 1 | Peripheral domain enable pulse |

## Verification
The assertions check several rules on every cycle. They check read-back after a write and holding while idle, and that the peripheral tick never repeats on back-to-back cycles. They also check that a ratio-1 core domain with the multiplier enabled ticks continuously, and that prescaled ticks stay isolated. Only the bench's scenarios can show the exact ratios taken from each code table and the divide-by-6 scaling. The same holds for the phase of the first tick after a write and the saturation of undefined codes. The bench compares every tick against a period model built from the tables.

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl #(
  parameter logic [15:0] RESET_VAL = 16'h0E0A,
  parameter int          PRE_DIV   = 6,
  parameter int          MUL_BIT   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] ctl_q,
  output logic        core_tick,
  output logic        bus_tick,
  output logic        per_tick
);
  localparam int PW = $clog2(PRE_DIV);
  localparam int ND = 3;

  function automatic logic [3:0] fast_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd4;
      3'd4: return 4'd5;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] slow_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 4'd2;
      3'd1: return 4'd3;
      3'd2: return 4'd4;
      3'd3: return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  logic [15:0]   ctl;
  logic [PW-1:0] pre_cnt;
  logic          pre_last;
  logic          qual;
  logic [3:0]    ratio [ND];
  logic [ND-1:0] tick;

  assign ctl_q    = ctl;
  assign pre_last = (pre_cnt == PW'(PRE_DIV - 1));
  assign qual     = ctl[MUL_BIT] | pre_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctl <= RESET_VAL;
    else if (wr_en) ctl <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               pre_cnt <= '0;
    else if (wr_en || ctl[MUL_BIT] || pre_last) pre_cnt <= '0;
    else                                      pre_cnt <= pre_cnt + 1'b1;

  assign ratio[0] = fast_ratio(ctl[8:6]);
  assign ratio[1] = fast_ratio(ctl[5:3]);
  assign ratio[2] = slow_ratio(ctl[2:0]);

  for (genvar d = 0; d < ND; d++) begin : g_dom
    logic [2:0] cnt;
    assign tick[d] = qual && ({1'b0, cnt} == ratio[d] - 4'd1);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt <= '0;
      else if (wr_en)   cnt <= '0;
      else if (tick[d]) cnt <= '0;
      else if (qual)    cnt <= cnt + 1'b1;
  end

  assign core_tick = tick[0];
  assign bus_tick  = tick[1];
  assign per_tick  = tick[2];
endmodule

module clk_ratio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] ctl_q,
  input logic        core_tick,
  input logic        bus_tick,
  input logic        per_tick
);
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl_q == $past(wr_data));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));
  p_per_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tick && !wr_en) |=> !per_tick);
  p_core_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[10] && ctl_q[8:6] == 3'd0) |-> core_tick);
  p_prescale_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[10] && (core_tick || bus_tick) && !wr_en) |=> !(core_tick || bus_tick));
endmodule

bind clk_ratio_ctrl clk_ratio_ctrl_chk u_chk (.*);

// File: tb/tb_clk_ratio_ctrl.sv
`timescale 1ns/1ps
module tb_clk_ratio_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] ctl_q;
  logic core_tick, bus_tick, per_tick;
  int checks = 0, failures = 0;
  int k = 0;
  logic [15:0] mctl = 16'h0E0A;
  bit running = 0;

  always #2.5 clk = ~clk;

  clk_ratio_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .core_tick(core_tick), .bus_tick(bus_tick), .per_tick(per_tick));

  function automatic int core_bus_n(input logic [2:0] c);
    int t [8] = '{1, 2, 3, 4, 5, 8, 8, 8};
    return t[c];
  endfunction
  function automatic int per_n(input logic [2:0] c);
    int t [8] = '{2, 3, 4, 6, 8, 8, 8, 8};
    return t[c];
  endfunction
  function automatic bit exp_tick(input int n, input logic mul, input int idx);
    int m = mul ? n : 6 * n;
    return ((idx + 1) % m) == 0;
  endfunction

  // R7 phase model: index since last reset or write edge
  always @(posedge clk)
    if (!rst_n) begin k <= 0; mctl <= 16'h0E0A; end
    else if (wr_en) begin k <= 0; mctl <= wr_data; end
    else k <= k + 1;

  task automatic chk(input bit act, input bit ex, input string tag);
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s k=%0d ctl=%h actual=%0b expected=%0b", tag, k, mctl, act, ex);
    end
  endtask

  always @(negedge clk)
    if (rst_n && running) begin
      string s6;
      s6 = mctl[10] ? " R7" : " R6 R7";
      chk(core_tick, exp_tick(core_bus_n(mctl[8:6]), mctl[10], k),
          (mctl[8:6] > 4) ? {"R9 core", s6} : {"R3 core", s6});
      chk(bus_tick, exp_tick(core_bus_n(mctl[5:3]), mctl[10], k),
          (mctl[5:3] > 4) ? {"R9 bus", s6} : {"R4 bus", s6});
      chk(per_tick, exp_tick(per_n(mctl[2:0]), mctl[10], k),
          (mctl[2:0] > 4) ? {"R9 per R8", s6} : {"R5 per R8", s6});
      checks++;
      if (ctl_q !== mctl) begin
        failures++;
        $display("FAIL R2 readback actual=%h expected=%h", ctl_q, mctl);
      end
    end

  task automatic wr(input logic [15:0] v, input int hold);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
    repeat (hold) begin
      wr_data = 16'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    checks++;
    if (ctl_q !== 16'h0E0A) begin
      failures++;
      $display("FAIL R1 reset value actual=%h expected=0e0a", ctl_q);
    end
    repeat (40) @(negedge clk);
    for (int mul = 1; mul >= 0; mul--)
      for (int c = 0; c < 8; c++) begin
        logic [2:0] cc = 3'(c);
        wr({5'h1F, mul[0], 1'b0, cc, cc, cc}, 6 * 8 * 2 + 4);
      end
    for (int i = 0; i < 30; i++)
      wr(16'($urandom), 20 + ($urandom % 100));
    wr(16'h0E0A, 5);
    wr(16'h0400, 3);
    wr(16'h0000, 60);
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule